// File: doc/BRIEF.md
# Interrupt Source Gateway Bank

This block sits between raw interrupt lines and a central interrupt arbiter. For every source it turns line activity into single-cycle request strobes, so that the arbiter sees at most one outstanding request per source. Each request passes through a fixed life cycle. It is issued, then claimed by a target, then completed. Only after completion may the gateway release the next request for that source.

A per-source mode bit picks how the line is read. In level mode the line is read as a level, and activity while a request is outstanding is dropped. In edge mode each rising transition of the line counts as one event. Events that arrive while a request is outstanding are stored in a saturating counter, up to a parameterised limit. Each later completion then releases one stored event as a fresh request.

The gateway instances are independent and are built by a generate loop, one per source. The number of sources and the pending limit are parameters.

Top module: `irq_gateway_bank`

## Requirements
- R1: After synchronous active-low reset, no source is in flight, every pending counter is zero, and `req_o` is all zeros.
- R2: Bit i of `edge_mode_i` selects the mode of source i: 0 means level mode, 1 means edge mode.
- R3: In level mode, a source with no request in flight whose line is sampled high at a clock edge raises its `req_o` bit right after that same edge.
- R4: In level mode, line activity while a request is in flight is ignored and nothing is stored. If the line is low when completion arrives, no further request follows.
- R5: In level mode, if the line is still high in the cycle that completion is sampled, a new request appears right after that edge.
- R6: In edge mode, only a low-to-high transition of the sampled line is an event. A line held high produces exactly one request.
- R7: In edge mode, events that arrive while a request is in flight are counted up to MAX_PEND. Further events are lost.
- R8: In edge mode, each completion with a nonzero count issues one request right after the completion edge and consumes one count.
- R9: A `req_o` bit is high for exactly one cycle. No second request for that source is issued until its completion has been sampled.
- R10: A claim strobe is accepted only while a request has been issued and not yet claimed. A completion strobe is accepted only after the claim. In any other state either strobe has no effect.
- R11: Sources operate independently of each other.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_i | input | NUM_SRC | Raw interrupt lines, one per source |
| edge_mode_i | input | NUM_SRC | Mode bit per source (0 level, 1 edge) |
| claim_i | input | NUM_SRC | Claim strobe per source |
| done_i | input | NUM_SRC | Completion strobe per source |
| req_o | output | NUM_SRC | Single-cycle request strobe per source toward the arbiter |

## Verification
The assertions assume that the raw lines are already synchronous to `clk`. They also assume that the strobes and the mode bits are stable around each sampling edge. The bench meets this by driving every input one time unit after the rising edge. The assertions do not assume that claim and completion come only in the legal order. The random stimulus therefore fires both strobes on arbitrary sources in arbitrary states, and mode bits are redrawn between segments. Directed sequences cover the count saturating, a stray completion while idle, and a level line held high across completion.

// File: rtl/irq_gw_pkg.sv
package irq_gw_pkg;

   typedef enum logic [1:0] {
      GW_IDLE    = 2'd0,
      GW_ISSUED  = 2'd1,
      GW_CLAIMED = 2'd2
   } gw_state_e;

endpackage

// File: rtl/irq_gw_edge.sv
module irq_gw_edge (
   input  logic clk,
   input  logic rst_n,
   input  logic line_i,
   output logic rise_o
);

   logic line_q;

   always_ff @(posedge clk) begin
      if (!rst_n) line_q <= 1'b0;
      else        line_q <= line_i;
   end

   assign rise_o = line_i & ~line_q;

endmodule

// File: rtl/irq_gw_queue.sv
module irq_gw_queue #(
   parameter int MAX_PEND = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic add_i,
   input  logic take_i,
   input  logic clr_i,
   output logic has_o
);

   localparam int CW = (MAX_PEND < 2) ? 1 : $clog2(MAX_PEND + 1);
   localparam logic [CW:0] LIMIT = (CW + 1)'(MAX_PEND);

   logic [CW-1:0] cnt_q;
   logic [CW:0]   sum;

   always_comb begin
      sum = {1'b0, cnt_q} + {{CW{1'b0}}, add_i} - {{CW{1'b0}}, take_i};
      if (sum > LIMIT) sum = LIMIT;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)      cnt_q <= '0;
      else if (clr_i)  cnt_q <= '0;
      else             cnt_q <= sum[CW-1:0];
   end

   assign has_o = (cnt_q != '0);

   p_cnt_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
      {1'b0, cnt_q} <= LIMIT);

   p_sat_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      ({1'b0, cnt_q} == LIMIT && add_i && !take_i && !clr_i) |=> ({1'b0, cnt_q} == LIMIT));

   p_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
      clr_i |=> !has_o);

endmodule

// File: rtl/irq_gw_lane.sv
module irq_gw_lane
   import irq_gw_pkg::*;
#(
   parameter int MAX_PEND = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic src_i,
   input  logic edge_mode_i,
   input  logic claim_i,
   input  logic done_i,
   output logic req_o
);

   gw_state_e state_q, state_d;
   logic      rise, has_pend, trig, issue, req_q;

   irq_gw_edge u_edge (
      .clk    (clk),
      .rst_n  (rst_n),
      .line_i (src_i),
      .rise_o (rise)
   );

   irq_gw_queue #(.MAX_PEND(MAX_PEND)) u_queue (
      .clk    (clk),
      .rst_n  (rst_n),
      .add_i  (edge_mode_i & rise),
      .take_i (edge_mode_i & issue),
      .clr_i  (~edge_mode_i),
      .has_o  (has_pend)
   );

   assign trig  = edge_mode_i ? (rise | has_pend) : src_i;
   assign issue = trig & ((state_q == GW_IDLE) |
                          ((state_q == GW_CLAIMED) & done_i));

   always_comb begin
      state_d = state_q;
      if (issue)                                   state_d = GW_ISSUED;
      else if (state_q == GW_ISSUED  && claim_i)   state_d = GW_CLAIMED;
      else if (state_q == GW_CLAIMED && done_i)    state_d = GW_IDLE;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= GW_IDLE;
         req_q   <= 1'b0;
      end else begin
         state_q <= state_d;
         req_q   <= issue;
      end
   end

   assign req_o = req_q;

   p_req_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
      req_q |=> !req_q);

   p_issued_blocks_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == GW_ISSUED) |=> !req_q);

   p_claim_order_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == GW_ISSUED && !claim_i) |=> (state_q == GW_ISSUED));

   p_stray_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == GW_IDLE && !trig) |=> (state_q == GW_IDLE && !req_q));

   p_level_reissue_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (!edge_mode_i && src_i && state_q == GW_CLAIMED && done_i) |=> req_q);

endmodule

// File: rtl/irq_gateway_bank.sv
module irq_gateway_bank #(
   parameter int NUM_SRC  = 4,
   parameter int MAX_PEND = 3
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] src_i,
   input  logic [NUM_SRC-1:0] edge_mode_i,
   input  logic [NUM_SRC-1:0] claim_i,
   input  logic [NUM_SRC-1:0] done_i,
   output logic [NUM_SRC-1:0] req_o
);

   if (NUM_SRC < 1) begin : g_chk_src
      $error("irq_gateway_bank: NUM_SRC must be at least 1");
   end
   if (MAX_PEND < 1) begin : g_chk_pend
      $error("irq_gateway_bank: MAX_PEND must be at least 1");
   end

   for (genvar i = 0; i < NUM_SRC; i++) begin : g_lane
      irq_gw_lane #(.MAX_PEND(MAX_PEND)) u_lane (
         .clk         (clk),
         .rst_n       (rst_n),
         .src_i       (src_i[i]),
         .edge_mode_i (edge_mode_i[i]),
         .claim_i     (claim_i[i]),
         .done_i      (done_i[i]),
         .req_o       (req_o[i])
      );
   end

   p_reset_quiet_r1: assert property (@(posedge clk)
      !rst_n |=> (req_o == '0));

endmodule

// File: tb/irq_gateway_bank_tb_top.sv
module irq_gateway_bank_tb_top;

   localparam int CLK_PERIOD = 10;
   localparam int N   = 4;
   localparam int MAXP = 3;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [N-1:0] src = '0, mode = '0, claim = '0, done = '0;
   logic [N-1:0] req;

   int checks = 0, errors = 0;
   bit finished = 0;

   // reference model state: 0 idle, 1 issued, 2 claimed
   int           m_st [N];
   int           m_cnt[N];
   logic [N-1:0] m_prev;
   logic [N-1:0] exp_req;

   always #(CLK_PERIOD/2) clk = ~clk;

   irq_gateway_bank #(.NUM_SRC(N), .MAX_PEND(MAXP)) dut_i (
      .clk(clk), .rst_n(rst_n), .src_i(src), .edge_mode_i(mode),
      .claim_i(claim), .done_i(done), .req_o(req)
   );

   function automatic int sat_cnt(int v);
      return (v > MAXP) ? MAXP : v;
   endfunction

   always @(posedge clk) begin
      for (int i = 0; i < N; i++) begin
         if (!rst_n) begin
            m_st[i] = 0; m_cnt[i] = 0; m_prev[i] = 1'b0; exp_req[i] = 1'b0;
         end else begin
            bit ev, trig, iss;
            ev   = src[i] && !m_prev[i];
            trig = mode[i] ? (ev || m_cnt[i] > 0) : src[i];
            iss  = trig && (m_st[i] == 0 || (m_st[i] == 2 && done[i]));
            if (mode[i]) m_cnt[i] = sat_cnt(m_cnt[i] + int'(ev) - int'(iss));
            else         m_cnt[i] = 0;
            if (iss)                          m_st[i] = 1;
            else if (m_st[i] == 1 && claim[i]) m_st[i] = 2;
            else if (m_st[i] == 2 && done[i])  m_st[i] = 0;
            exp_req[i] = iss;
            m_prev[i]  = src[i];
         end
      end
   end

   task automatic chk(string tag, logic [N-1:0] act, logic [N-1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: req_o actual %b expected %b at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic step();
      @(posedge clk);
      #1;
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      if (!finished) begin
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      step(); step();
      chk("R1 reset", req, '0);
      rst_n = 1'b1;
      step();
      chk("R1 after reset", req, '0);

      // R2/R3: source 0 in level mode
      mode = 4'b0010;
      src[0] = 1'b1;
      step();
      chk("R3 level request", req, 4'b0001);
      step();
      chk("R9 one-cycle strobe", req, 4'b0000);
      claim[0] = 1'b1; step(); claim[0] = 1'b0;
      chk("R9 no request while claimed", req, 4'b0000);
      done[0] = 1'b1; step(); done[0] = 1'b0;
      chk("R5 level line high at completion", req, 4'b0001);
      // R4: toggle the line while in flight
      src[0] = 1'b0; step();
      src[0] = 1'b1; step();
      chk("R4 level toggle ignored", req, 4'b0000);
      src[0] = 1'b0; step();
      claim[0] = 1'b1; step(); claim[0] = 1'b0;
      done[0] = 1'b1; step(); done[0] = 1'b0;
      chk("R4 no request after completion with line low", req, 4'b0000);
      step();
      chk("R4 nothing stored", req, 4'b0000);

      // R6: source 1 edge mode, held high
      src[1] = 1'b1; step();
      chk("R6 rising edge request", req, 4'b0010);
      claim[1] = 1'b1; step(); claim[1] = 1'b0;
      done[1] = 1'b1; step(); done[1] = 1'b0;
      chk("R6 held line gives no second request", req, 4'b0000);
      src[1] = 1'b0; step();
      src[1] = 1'b1; step();
      chk("R6 new edge gives request", req, 4'b0010);
      // R7: five more edges while in flight, count saturates at MAXP
      for (int k = 0; k < 5; k++) begin
         src[1] = 1'b0; step();
         src[1] = 1'b1; step();
      end
      chk("R9 no request while issued", req, 4'b0000);
      for (int k = 0; k < MAXP + 1; k++) begin
         claim[1] = 1'b1; step(); claim[1] = 1'b0;
         done[1] = 1'b1; step(); done[1] = 1'b0;
         chk(k < MAXP ? "R8 queued event released" : "R7 excess events lost",
             req, (k < MAXP) ? 4'b0010 : 4'b0000);
      end

      // R10: stray strobes while idle
      src = '0; step(); step();
      done = '1; step(); done = '0;
      chk("R10 stray completion", req, 4'b0000);
      claim = '1; step(); claim = '0;
      chk("R10 stray claim", req, 4'b0000);
      mode[2] = 1'b1; src[2] = 1'b1; step();
      chk("R10 state unchanged, edge accepted", req, 4'b0100);
      claim[2] = 1'b1; step(); claim[2] = 1'b0;
      done[2]  = 1'b1; step(); done[2]  = 1'b0;
      src = '0; step(); step();

      // R11 and all rules: random stimulus against the model
      void'($urandom(32'd1234));
      for (int c = 0; c < 4000; c++) begin
         if (c % 250 == 0) mode = N'($urandom);
         for (int i = 0; i < N; i++) begin
            src[i]   = ($urandom % 4) == 0 ? ~src[i] : src[i];
            claim[i] = ($urandom % 3) == 0;
            done[i]  = ($urandom % 4) == 0;
         end
         step();
         chk("R11 random vs model", req, exp_req);
      end

      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule